// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-line interrupt controller. Each request line is captured into a request register, either by its level or by a rising edge, as a per-line mode input selects. Requests that are not masked compete by priority against the lines already in service. When a pending request beats every in-service line, a registered interrupt output goes high toward the processor.

The priority order rotates. A base register names the line that currently holds the top rank. The other lines follow in ascending index order, wrapping around. An acknowledge strobe reports the winning line number and records it as in service. End-of-interrupt operations arrive as single-cycle strobes with an operation code. They retire in-service lines and can move the rotation base. The mask, trigger modes and mode flags are plain input ports, driven by whatever command decoder sits above this block.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous reset clears the request, in-service, previous-level and base registers and the interrupt output. With nothing pending, `ack_id` reads 7.
- R2: A line with `level_sel` high is level triggered. On every clock its request bit takes the line's input value, so a low input clears a pending request.
- R3: A line with `level_sel` low is edge triggered. Its request bit is set only when the input is high and was low on the previous clock. Holding the input high raises no further request.
- R4: The rank of line i is (i − base) mod 8, and a lower rank wins. `ack_id` names the pending, unmasked line of lowest rank.
- R5: A line whose `mask_in` bit is high takes no part in the competition, and it is never reported while masked.
- R6: `int_out` is registered. One clock after the state allows it, `int_out` is high exactly when the best pending rank is strictly lower than the best in-service rank. An empty set ranks 8.
- R7: An acknowledge with a valid winner sets that line's in-service bit. The request bit is cleared only for an edge-triggered line, so a level line stays pending.
- R8: With `nest_en` high, in-service bit 2 is left out of the in-service rank, so a new request on line 2 can be raised while line 2 is in service.
- R9: With `aeoi_en` high, an acknowledge leaves the in-service register unchanged. If `aeoi_rot_en` is also high, the base becomes the acknowledged line + 1 mod 8.
- R10: `eoi_op` = 1 clears the in-service bit of lowest rank. `eoi_op` = 2 does the same and also sets the base to that line + 1 mod 8. With nothing in service, both leave all state unchanged.
- R11: `eoi_op` = 3 clears in-service bit `eoi_id`, and `eoi_op` = 4 also sets the base to `eoi_id` + 1 mod 8. `eoi_op` = 5 sets the base to `eoi_id` + 1 mod 8 without touching the in-service register. Codes 0, 6 and 7 do nothing.
- R12: An acknowledge with no valid winner reports line 7 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Request lines |
| level_sel | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_in | input | 8 | Per-line mask, 1 = masked |
| aeoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| aeoi_rot_en | input | 1 | Rotate the base on automatic end-of-interrupt |
| nest_en | input | 1 | Exclude in-service bit 2 from the in-service rank |
| ack | input | 1 | Acknowledge strobe, one cycle |
| eoi_op | input | 3 | End-of-interrupt operation code, sampled each cycle |
| eoi_id | input | 3 | Line number or base value used by the operation |
| int_out | output | 1 | Registered interrupt request to the processor |
| ack_id | output | 3 | Current winning line, 7 when there is none |

## Verification
The assertions assume that an acknowledge and an end-of-interrupt operation never arrive in the same cycle. They also assume that `level_sel` for a line does not change while that line has a request pending. The bench issues each strobe from its own task with a full clock between strobes. It changes trigger modes only while the affected line is low and idle. Each scenario returns the in-service register to empty and the base to 0 before the next one starts.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N        = 8,
  parameter int NEST_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         irq_in,
  input  logic [N-1:0]         level_sel,
  input  logic [N-1:0]         mask_in,
  input  logic                 aeoi_en,
  input  logic                 aeoi_rot_en,
  input  logic                 nest_en,
  input  logic                 ack,
  input  logic [2:0]           eoi_op,
  input  logic [$clog2(N)-1:0] eoi_id,
  output logic                 int_out,
  output logic [$clog2(N)-1:0] ack_id
);
  localparam int IW = $clog2(N);
  localparam logic [2:0] OP_NS = 3'd1, OP_NS_ROT = 3'd2, OP_SP = 3'd3,
                         OP_SP_ROT = 3'd4, OP_SET_BASE = 3'd5;
  localparam logic [IW:0] EMPTY = (IW+1)'(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [IW:0] best_rank(input logic [N-1:0] v, input logic [IW-1:0] b);
    logic [IW:0] r;
    r = EMPTY;
    for (int k = N - 1; k >= 0; k--)
      if (v[IW'((k + int'(b)) % N)]) r = (IW+1)'(k);
    return r;
  endfunction

  function automatic logic [IW-1:0] line_of(input logic [IW:0] r, input logic [IW-1:0] b);
    return IW'((int'(r) + int'(b)) % N);
  endfunction

  function automatic logic [IW-1:0] next_of(input logic [IW-1:0] i);
    return IW'((int'(i) + 1) % N);
  endfunction

  logic [N-1:0]  req_q, prev_q, isr_q;
  logic [IW-1:0] base_q;
  logic          int_q;

  logic [N-1:0]  pend, isr_cmp, nest_hole;
  logic [IW:0]   req_rank, svc_rank, top_rank;
  logic [IW-1:0] win_id, top_id;
  logic          win_ok, ack_go;

  assign nest_hole = nest_en ? (ONE << NEST_BIT) : '0;
  assign pend      = req_q & ~mask_in;
  assign isr_cmp   = isr_q & ~nest_hole;
  assign req_rank  = best_rank(pend, base_q);
  assign svc_rank  = best_rank(isr_cmp, base_q);
  assign top_rank  = best_rank(isr_q, base_q);
  assign win_id    = line_of(req_rank, base_q);
  assign top_id    = line_of(top_rank, base_q);
  assign win_ok    = req_rank < svc_rank;
  assign ack_go    = ack & win_ok;
  assign ack_id    = win_ok ? win_id : IW'(N - 1);
  assign int_out   = int_q;

  logic [N-1:0]  win_bit, isr_set, isr_clr, edge_clr, rise;
  logic [IW-1:0] base_d;
  logic          have_top;

  assign win_bit  = ONE << win_id;
  assign have_top = top_rank != EMPTY;
  assign isr_set  = (ack_go && !aeoi_en) ? win_bit : '0;
  assign edge_clr = ack_go ? (win_bit & ~level_sel) : '0;
  assign rise     = irq_in & ~prev_q;

  always_comb begin
    isr_clr = '0;
    base_d  = base_q;
    unique case (eoi_op)
      OP_NS:       if (have_top) isr_clr = ONE << top_id;
      OP_NS_ROT:   if (have_top) begin
                     isr_clr = ONE << top_id;
                     base_d  = next_of(top_id);
                   end
      OP_SP:       isr_clr = ONE << eoi_id;
      OP_SP_ROT:   begin
                     isr_clr = ONE << eoi_id;
                     base_d  = next_of(eoi_id);
                   end
      OP_SET_BASE: base_d = next_of(eoi_id);
      default:     ;
    endcase
    if (ack_go && aeoi_en && aeoi_rot_en) base_d = next_of(win_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      prev_q <= '0;
      isr_q  <= '0;
      base_q <= '0;
      int_q  <= 1'b0;
    end else begin
      req_q  <= (level_sel & irq_in) | (~level_sel & ((req_q & ~edge_clr) | rise));
      prev_q <= irq_in;
      isr_q  <= (isr_q | isr_set) & ~isr_clr;
      base_q <= base_d;
      int_q  <= win_ok;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         irq_in,
  input logic [N-1:0]         level_sel,
  input logic [N-1:0]         mask_in,
  input logic                 aeoi_en,
  input logic                 ack,
  input logic [2:0]           eoi_op,
  input logic                 int_out,
  input logic [$clog2(N)-1:0] ack_id,
  input logic [N-1:0]         req_q,
  input logic [N-1:0]         prev_q,
  input logic [N-1:0]         isr_q,
  input logic [$clog2(N)-1:0] base_q
);
  localparam int IW = $clog2(N);

  assert_level_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_q ^ $past(irq_in)) & $past(level_sel)) == '0);

  assert_edge_only_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req_q & ~$past(req_q) & ~$past(level_sel) & ~($past(irq_in) & ~$past(prev_q))) == '0);

  assert_int_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(req_q & ~mask_in)));

  assert_ack_marks_service_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !aeoi_en && eoi_op == 3'd0) |=>
      (isr_q[$past(ack_id)] || $past(ack_id) == IW'(N - 1)));

  assert_auto_eoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && aeoi_en && eoi_op == 3'd0) |=> isr_q == $past(isr_q));

  assert_empty_eoi_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ((eoi_op == 3'd1 || eoi_op == 3'd2) && isr_q == '0 && !ack) |=>
      ($stable(base_q) && isr_q == '0));

  assert_spurious_id_R12: assert property (@(posedge clk) disable iff (rst)
    (ack && (req_q & ~mask_in) == '0) |-> ack_id == IW'(N - 1));
endmodule

bind irq_resolver irq_resolver_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .level_sel(level_sel),
  .mask_in(mask_in), .aeoi_en(aeoi_en), .ack(ack), .eoi_op(eoi_op),
  .int_out(int_out), .ack_id(ack_id), .req_q(req_q), .prev_q(prev_q),
  .isr_q(isr_q), .base_q(base_q)
);

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0, level_sel = '0, mask_in = '0;
  logic       aeoi_en = 1'b0, aeoi_rot_en = 1'b0, nest_en = 1'b0, ack = 1'b0;
  logic [2:0] eoi_op = '0, eoi_id = '0;
  logic       int_out;
  logic [2:0] ack_id;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  irq_resolver u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_sel(level_sel),
    .mask_in(mask_in), .aeoi_en(aeoi_en), .aeoi_rot_en(aeoi_rot_en),
    .nest_en(nest_en), .ack(ack), .eoi_op(eoi_op), .eoi_id(eoi_id),
    .int_out(int_out), .ack_id(ack_id)
  );

  always #2 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic see(string tag, int i_exp, int id_exp);
    chk({tag, " int_out"}, int'(int_out), i_exp);
    chk({tag, " ack_id"}, int'(ack_id), id_exp);
  endtask

  task automatic pulse(logic [7:0] lines);
    irq_in = irq_in | lines; step();
    irq_in = irq_in & ~lines; step();
  endtask

  task automatic do_ack;
    ack = 1'b1; step(); ack = 1'b0; step();
  endtask

  task automatic do_eoi(logic [2:0] op, logic [2:0] id);
    eoi_op = op; eoi_id = id; step(); eoi_op = '0; eoi_id = '0; step();
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3); rst = 1'b0; step();
    see("R1 reset", 0, 7);
  endtask

  task automatic t_edge;
    irq_in[3] = 1'b1; step(2);
    see("R3 edge capture", 1, 3);
    do_ack();
    chk("R7 edge ack clears request", int'(int_out), 0);
    do_eoi(3'd1, 3'd0);
    chk("R3 held input no new request", int'(int_out), 0);
    irq_in[3] = 1'b0; step();
    irq_in[3] = 1'b1; step(2);
    see("R3 second rise", 1, 3);
    do_ack(); irq_in[3] = 1'b0; do_eoi(3'd1, 3'd0);
  endtask

  task automatic t_level;
    level_sel[5] = 1'b1; irq_in[5] = 1'b1; step(2);
    see("R2 level capture", 1, 5);
    do_ack();
    chk("R6 equal rank not raised", int'(int_out), 0);
    do_eoi(3'd1, 3'd0);
    see("R7 level stays pending", 1, 5);
    irq_in[5] = 1'b0; step(2);
    see("R2 low input clears", 0, 7);
    level_sel[5] = 1'b0; step();
  endtask

  task automatic t_priority;
    pulse(8'b0001_0010);
    see("R4 lower index wins", 1, 1);
    do_ack();
    chk("R6 worse request blocked", int'(int_out), 0);
    pulse(8'b0000_0001);
    see("R6 better request raised", 1, 0);
    do_ack();
    do_eoi(3'd1, 3'd0);
    chk("R10 clears top only", int'(int_out), 0);
    do_eoi(3'd1, 3'd0);
    see("R10 second eoi", 1, 4);
    do_ack(); do_eoi(3'd1, 3'd0);
    see("R10 idle after clean", 0, 7);
  endtask

  task automatic t_mask;
    mask_in[6] = 1'b1; pulse(8'b0100_0000);
    see("R5 masked hidden", 0, 7);
    mask_in[6] = 1'b0; step(2);
    see("R5 unmasked shown", 1, 6);
    do_ack(); do_eoi(3'd1, 3'd0);
  endtask

  task automatic t_rotate;
    do_eoi(3'd5, 3'd3);
    pulse(8'b0010_0100);
    see("R11 set base rank", 1, 5);
    do_ack();
    chk("R4 rotated rank blocks", int'(int_out), 0);
    do_eoi(3'd4, 3'd5);
    see("R11 specific rotate", 1, 2);
    pulse(8'b1000_0000);
    see("R4 line 7 outranks 2", 1, 7);
    do_ack(); do_eoi(3'd1, 3'd0);
    see("R10 after clearing 7", 1, 2);
    do_ack(); do_eoi(3'd2, 3'd0);
    pulse(8'b0000_1000);
    see("R10 rotate base to 3", 1, 3);
    do_ack(); do_eoi(3'd1, 3'd0);
    do_ack(); do_eoi(3'd1, 3'd0);
    do_eoi(3'd6, 3'd4);
    do_eoi(3'd5, 3'd7);
    see("R11 restored", 0, 7);
  endtask

  task automatic t_specific;
    pulse(8'b0000_0010); do_ack();
    pulse(8'b0000_0001); do_ack();
    do_eoi(3'd3, 3'd1);
    do_eoi(3'd1, 3'd0);
    pulse(8'b0000_1000);
    see("R11 specific cleared named line", 1, 3);
    do_ack(); do_eoi(3'd1, 3'd0);
  endtask

  task automatic t_empty_eoi;
    do_eoi(3'd2, 3'd0);
    pulse(8'b1000_0001);
    see("R10 empty eoi keeps base", 1, 0);
    do_ack(); do_eoi(3'd1, 3'd0);
    do_ack(); do_eoi(3'd1, 3'd0);
    do_ack();
    see("R12 spurious ack no change", 0, 7);
  endtask

  task automatic t_auto;
    aeoi_en = 1'b1;
    pulse(8'b0001_0000); do_ack();
    pulse(8'b0100_0000);
    see("R9 auto eoi leaves nothing", 1, 6);
    aeoi_rot_en = 1'b1; do_ack();
    pulse(8'b1000_0001);
    see("R9 rotate on auto eoi", 1, 7);
    do_ack();
    see("R9 base moved to 0", 1, 0);
    do_ack();
    aeoi_en = 1'b0; aeoi_rot_en = 1'b0;
    do_eoi(3'd5, 3'd7);
    see("R9 idle", 0, 7);
  endtask

  task automatic t_nested;
    pulse(8'b0000_0100); do_ack();
    pulse(8'b0000_0100);
    chk("R8 off blocks line 2", int'(int_out), 0);
    nest_en = 1'b1; step(2);
    see("R8 on raises line 2", 1, 2);
    do_ack();
    nest_en = 1'b0; do_eoi(3'd1, 3'd0);
    see("R8 clean", 0, 7);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_priority();
    t_mask();
    t_rotate();
    t_specific();
    t_empty_eoi();
    t_auto();
    t_nested();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule